// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a 32-bit processor core. It has sixteen visible general registers, a current status word and a saved status word. Which physical storage stands behind a register number depends on the operating mode, which is held in the low five bits of the current status word. The shared registers (numbers 0 to 7 and 15) have a single copy that every mode sees. Numbers 8 to 12 have a second copy that the fast-interrupt mode uses. Numbers 13 and 14 have one copy for each privilege context. Each exception mode also has its own saved status word.

Two read ports return data combinationally for any 4-bit register number. One write port stores a register on the clock edge. The current status word has its own write port. A write that changes the mode field moves the whole register view to the new mode's copies in one step, without copying any data. The block also reports the active mode, whether that mode is privileged, whether it owns a saved status word, and whether the last status write carried a mode code the block does not recognise.

Top module: `mode_banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000DF and the active mode is System (0b11111). Every general register reads zero. The saved-status read gives zero. Privileged is 1, has-saved is 0 and bad-mode is 0.
- R2: Registers 0 to 7 and 15 have one physical copy. A value written in any mode is read back unchanged in every other mode.
- R3: Registers 8 to 12 have two copies. One is used only in fast-interrupt mode (0b10001) and the other in all remaining modes.
- R4: Registers 13 and 14 have six copies. User (0b10000) and System (0b11111) share one copy. Supervisor (0b10011), Abort (0b10111), Undefined (0b11011), IRQ (0b10010) and fast-interrupt (0b10001) each have a private copy.
- R5: Supervisor, Abort, Undefined, IRQ and fast-interrupt mode each have a private saved status word. In User or System mode a saved-status read returns zero and a saved-status write changes nothing.
- R6: The privileged output is 0 only in User mode. The has-saved output is 0 only in User and System mode.
- R7: A status write whose low five bits equal the current ones updates the status word and leaves the register mapping unchanged.
- R8: A status write that carries a different, recognised mode code makes that mode active from the next cycle. A general-register or saved-status write in the same cycle goes to the copy of the old mode.
- R9: A status write whose mode code is not one of the seven above stores the word and sets bad-mode to 1. The active mode and the mapping stay as they were. The bad-mode output follows each later status write, and mode_o always shows the active, recognised mode.
- R10: Both read ports return the currently mapped copy combinationally. A write is visible on both ports from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr_a | input | 4 | Register number, read port A |
| rd_data_a | output | 32 | Read data, port A |
| rd_addr_b | input | 4 | Register number, read port B |
| rd_data_b | output | 32 | Read data, port B |
| wr_en | input | 1 | General register write enable |
| wr_addr | input | 4 | General register write number |
| wr_data | input | 32 | General register write data |
| stat_wr_en | input | 1 | Current status write enable |
| stat_wr_data | input | 32 | Current status write data; bits 4:0 are the mode |
| stat_q | output | 32 | Current status word |
| saved_wr_en | input | 1 | Saved status write enable |
| saved_wr_data | input | 32 | Saved status write data |
| saved_rd_data | output | 32 | Saved status of the active mode, zero in User/System |
| mode_o | output | 5 | Active recognised mode code |
| priv_o | output | 1 | Active mode is privileged |
| has_saved_o | output | 1 | Active mode owns a saved status word |
| bad_mode_o | output | 1 | Last status write carried an unrecognised mode code |

## Verification
The assertions assume each input is either held or driven to a known value on every cycle after reset. In particular, the enables are never X. The mapping checks also rely on the active mode only ever being one of the seven recognised codes, which the block itself ensures. The stimulus drives every input from the bench on the falling edge. It changes modes through the seven recognised codes and two unrecognised ones (0b00000 and 0b10100). Over long random stretches it mixes general writes, saved-status writes and mode switches in the same cycle, so the old-mode write rule and the ignored saved writes are both covered.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int unsigned MODE_W        = 5;
  localparam int unsigned ADDR_W        = 4;
  localparam int unsigned N_SHARED      = 9;
  localparam int unsigned N_HI          = 5;
  localparam int unsigned N_HI_COPIES   = 2;
  localparam int unsigned N_STACK_BANKS = 6;
  localparam int unsigned N_STACK_REGS  = 2;
  localparam int unsigned N_SAVED       = 5;
  localparam int unsigned IDX_W         = 3;

  localparam logic [MODE_W-1:0] MODE_USER   = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FAST   = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ    = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SUPV   = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABORT  = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UNDEF  = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYSTEM = 5'b11111;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USER, MODE_FAST, MODE_IRQ, MODE_SUPV,
      MODE_ABORT, MODE_UNDEF, MODE_SYSTEM: return 1'b1;
      default:                             return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/regbank_mode_dec.sv
module regbank_mode_dec
  import regbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              fast_o,
  output logic              priv_o,
  output logic              has_saved_o,
  output logic [IDX_W-1:0]  stack_idx_o,
  output logic [IDX_W-1:0]  saved_idx_o
);
  always_comb begin
    fast_o      = 1'b0;
    priv_o      = 1'b1;
    has_saved_o = 1'b1;
    stack_idx_o = '0;
    saved_idx_o = '0;
    case (mode_i)
      MODE_USER:   begin priv_o = 1'b0; has_saved_o = 1'b0; end
      MODE_SYSTEM: begin has_saved_o = 1'b0; end
      MODE_SUPV:   begin stack_idx_o = 3'd1; saved_idx_o = 3'd0; end
      MODE_ABORT:  begin stack_idx_o = 3'd2; saved_idx_o = 3'd1; end
      MODE_UNDEF:  begin stack_idx_o = 3'd3; saved_idx_o = 3'd2; end
      MODE_IRQ:    begin stack_idx_o = 3'd4; saved_idx_o = 3'd3; end
      MODE_FAST:   begin stack_idx_o = 3'd5; saved_idx_o = 3'd4; fast_o = 1'b1; end
      default:     begin priv_o = 1'b0; has_saved_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/regbank_psr.sv
module regbank_psr
  import regbank_pkg::*;
#(
  parameter int unsigned   DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00DF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              saved_wr_en,
  input  logic [DATA_W-1:0] saved_wr_data,
  input  logic              cur_has_saved,
  input  logic [IDX_W-1:0]  cur_saved_idx,
  output logic [DATA_W-1:0] status_q,
  output logic [MODE_W-1:0] act_mode_q,
  output logic              bad_q,
  output logic [DATA_W-1:0] saved_rd
);
  logic [DATA_W-1:0]                 status_d;
  logic [MODE_W-1:0]                 act_mode_d;
  logic                              bad_d;
  logic [N_SAVED-1:0][DATA_W-1:0]    saved_q, saved_d;
  logic                              new_legal;
  logic                              mode_differs;

  assign new_legal    = mode_legal(wr_data[MODE_W-1:0]);
  assign mode_differs = wr_data[MODE_W-1:0] != status_q[MODE_W-1:0];

  always_comb begin
    status_d   = status_q;
    act_mode_d = act_mode_q;
    bad_d      = bad_q;
    saved_d    = saved_q;
    if (wr_en) begin
      status_d = wr_data;
      bad_d    = !new_legal;
      if (mode_differs && new_legal) act_mode_d = wr_data[MODE_W-1:0];
    end
    if (saved_wr_en && cur_has_saved) saved_d[cur_saved_idx] = saved_wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= RESET_VAL;
      act_mode_q <= RESET_VAL[MODE_W-1:0];
      bad_q      <= 1'b0;
      saved_q    <= '0;
    end else begin
      status_q   <= status_d;
      act_mode_q <= act_mode_d;
      bad_q      <= bad_d;
      saved_q    <= saved_d;
    end
  end

  assign saved_rd = cur_has_saved ? saved_q[cur_saved_idx] : '0;

  assert_map_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !new_legal |=> $stable(act_mode_q));

  assert_same_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !mode_differs |=> $stable(act_mode_q));

  assert_switch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && new_legal && mode_differs |=> act_mode_q == $past(wr_data[MODE_W-1:0]));

  assert_no_saved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    saved_wr_en && !cur_has_saved |=> $stable(saved_q));
endmodule

// File: rtl/regbank_gpr.sv
module regbank_gpr
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_RD   = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         fast_i,
  input  logic [IDX_W-1:0]             stack_idx_i,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [N_RD-1:0][ADDR_W-1:0]  rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0]  rd_data_o
);
  logic [DATA_W-1:0] shared_q [N_SHARED];
  logic [DATA_W-1:0] hi_q     [N_HI_COPIES][N_HI];
  logic [DATA_W-1:0] stk_q    [N_STACK_BANKS][N_STACK_REGS];

  for (genvar g = 0; g < N_SHARED; g++) begin : g_shared
    localparam logic [ADDR_W-1:0] ADDR = (g < 8) ? ADDR_W'(g) : ADDR_W'(15);
    logic we;
    assign we = wr_en && (wr_addr == ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  shared_q[g] <= '0;
      else if (we) shared_q[g] <= wr_data;
    end
  end

  for (genvar c = 0; c < N_HI_COPIES; c++) begin : g_hi_copy
    for (genvar h = 0; h < N_HI; h++) begin : g_hi
      logic we;
      assign we = wr_en && (wr_addr == ADDR_W'(8 + h)) && (fast_i == (c == 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  hi_q[c][h] <= '0;
        else if (we) hi_q[c][h] <= wr_data;
      end
    end
  end

  for (genvar b = 0; b < N_STACK_BANKS; b++) begin : g_stk_bank
    for (genvar k = 0; k < N_STACK_REGS; k++) begin : g_stk
      logic we;
      assign we = wr_en && (wr_addr == ADDR_W'(13 + k)) && (stack_idx_i == IDX_W'(b));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  stk_q[b][k] <= '0;
        else if (we) stk_q[b][k] <= wr_data;
      end
    end
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic [ADDR_W-1:0] a;
    assign a = rd_addr_i[p];
    always_comb begin
      if (a <= 4'd7)       rd_data_o[p] = shared_q[a[2:0]];
      else if (a == 4'd15) rd_data_o[p] = shared_q[8];
      else if (a <= 4'd12) rd_data_o[p] = hi_q[fast_i][a[2:0]];
      else                 rd_data_o[p] = stk_q[stack_idx_i][a[1]];
    end
  end

  assert_port_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr_i[0] == rd_addr_i[N_RD-1] |-> rd_data_o[0] == rd_data_o[N_RD-1]);
endmodule

// File: rtl/mode_banked_regfile.sv
module mode_banked_regfile
  import regbank_pkg::*;
#(
  parameter int unsigned       DATA_W    = 32,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00DF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_addr_a,
  output logic [DATA_W-1:0] rd_data_a,
  input  logic [3:0]        rd_addr_b,
  output logic [DATA_W-1:0] rd_data_b,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_wr_en,
  input  logic [DATA_W-1:0] stat_wr_data,
  output logic [DATA_W-1:0] stat_q,
  input  logic              saved_wr_en,
  input  logic [DATA_W-1:0] saved_wr_data,
  output logic [DATA_W-1:0] saved_rd_data,
  output logic [4:0]        mode_o,
  output logic              priv_o,
  output logic              has_saved_o,
  output logic              bad_mode_o
);
  logic [MODE_W-1:0]          act_mode;
  logic                       fast;
  logic [IDX_W-1:0]           stack_idx;
  logic [IDX_W-1:0]           saved_idx;
  logic [1:0][ADDR_W-1:0]     rd_addr;
  logic [1:0][DATA_W-1:0]     rd_data;

  regbank_mode_dec u_dec (
    .mode_i      (act_mode),
    .fast_o      (fast),
    .priv_o      (priv_o),
    .has_saved_o (has_saved_o),
    .stack_idx_o (stack_idx),
    .saved_idx_o (saved_idx)
  );

  regbank_psr #(.DATA_W(DATA_W), .RESET_VAL(RESET_VAL)) u_psr (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (stat_wr_en),
    .wr_data       (stat_wr_data),
    .saved_wr_en   (saved_wr_en),
    .saved_wr_data (saved_wr_data),
    .cur_has_saved (has_saved_o),
    .cur_saved_idx (saved_idx),
    .status_q      (stat_q),
    .act_mode_q    (act_mode),
    .bad_q         (bad_mode_o),
    .saved_rd      (saved_rd_data)
  );

  assign rd_addr = {rd_addr_b, rd_addr_a};

  regbank_gpr #(.DATA_W(DATA_W), .N_RD(2)) u_gpr (
    .clk         (clk),
    .rst_n       (rst_n),
    .fast_i      (fast),
    .stack_idx_i (stack_idx),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data)
  );

  assign rd_data_a = rd_data[0];
  assign rd_data_b = rd_data[1];
  assign mode_o    = act_mode;

  assert_priv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !priv_o |-> !has_saved_o);
endmodule

// File: tb/sim_mode_banked_regfile.sv
`timescale 1ns/1ps
module sim_mode_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
  logic        wr_en = 1'b0, stat_wr_en = 1'b0, saved_wr_en = 1'b0;
  logic [31:0] stat_wr_data = '0, stat_q, saved_wr_data = '0, saved_rd_data;
  logic [4:0]  mode_o;
  logic        priv_o, has_saved_o, bad_mode_o;

  always #2.5 clk = ~clk;

  mode_banked_regfile u0 (.*);

  // behavioural reference model
  logic [31:0] m_store [0:127];
  logic [31:0] m_saved [0:4];
  logic [31:0] m_stat;
  logic [4:0]  m_mode;
  logic        m_bad;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit done = 0;

  function automatic int saved_key(input logic [4:0] m);
    case (m)
      5'b10011: return 0;
      5'b10111: return 1;
      5'b11011: return 2;
      5'b10010: return 3;
      5'b10001: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic bit is_legal(input logic [4:0] m);
    return saved_key(m) >= 0 || m == 5'b10000 || m == 5'b11111;
  endfunction

  function automatic int reg_key(input logic [4:0] m, input int a);
    if (a < 8 || a == 15) return a;
    if (a <= 12) return (m == 5'b10001) ? 16 + a : a;
    case (m)
      5'b10011: return 32 + a;
      5'b10111: return 48 + a;
      5'b11011: return 64 + a;
      5'b10010: return 80 + a;
      5'b10001: return 96 + a;
      default:  return a;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) m_store[i] = '0;
      for (int i = 0; i < 5; i++) m_saved[i] = '0;
      m_stat = 32'h0000_00DF;
      m_mode = 5'b11111;
      m_bad  = 1'b0;
    end else begin
      if (wr_en) m_store[reg_key(m_mode, int'(wr_addr))] = wr_data;
      if (saved_wr_en && saved_key(m_mode) >= 0) m_saved[saved_key(m_mode)] = saved_wr_data;
      if (stat_wr_en) begin
        if (stat_wr_data[4:0] != m_stat[4:0] && is_legal(stat_wr_data[4:0]))
          m_mode = stat_wr_data[4:0];
        m_bad  = !is_legal(stat_wr_data[4:0]);
        m_stat = stat_wr_data;
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("rd_a", rd_data_a, m_store[reg_key(m_mode, int'(rd_addr_a))]);
    chk("rd_b", rd_data_b, m_store[reg_key(m_mode, int'(rd_addr_b))]);
    chk("stat", stat_q, m_stat);
    chk("saved", saved_rd_data, saved_key(m_mode) >= 0 ? m_saved[saved_key(m_mode)] : 32'h0);
    chk("mode", 32'(mode_o), 32'(m_mode));
    chk("priv", 32'(priv_o), 32'(m_mode != 5'b10000));
    chk("has_saved", 32'(has_saved_o), 32'(saved_key(m_mode) >= 0));
    chk("bad", 32'(bad_mode_o), 32'(m_bad));
  endtask

  // one cycle: inputs are applied now, checked after the edge
  task automatic op(input bit w, input logic [3:0] wa, input logic [31:0] wd,
                    input bit pw, input logic [31:0] pd,
                    input bit sw, input logic [31:0] sd,
                    input logic [3:0] ra, input logic [3:0] rb);
    wr_en = w; wr_addr = wa; wr_data = wd;
    stat_wr_en = pw; stat_wr_data = pd;
    saved_wr_en = sw; saved_wr_data = sd;
    rd_addr_a = ra; rd_addr_b = rb;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic set_mode(input logic [4:0] m, input logic [26:0] upper);
    op(0, 0, 0, 1, {upper, m}, 0, 0, 0, 15);
  endtask

  task automatic sweep_reads();
    for (int a = 0; a < 16; a++) op(0, 0, 0, 0, 0, 0, 0, 4'(a), 4'(15 - a));
  endtask

  localparam logic [4:0] MODES [0:6] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                         5'b10111, 5'b11011, 5'b11111};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1"; compare_all();
    sweep_reads();

    cur_req = "R2";
    for (int a = 0; a < 16; a++) op(1, 4'(a), 32'h1000_0000 + 32'(a), 0, 0, 0, 0, 4'(a), 4'(a));
    cur_req = "R10";
    sweep_reads();

    cur_req = "R4";
    for (int i = 0; i < 7; i++) begin
      set_mode(MODES[i], 27'(i));
      for (int a = 8; a < 15; a++)
        op(1, 4'(a), 32'hA000_0000 + 32'(i * 256 + a), 0, 0, 0, 0, 4'(a), 4'(a - 1));
    end
    cur_req = "R3";
    for (int i = 0; i < 7; i++) begin
      set_mode(MODES[i], 27'h55);
      sweep_reads();
    end

    cur_req = "R5";
    for (int i = 0; i < 7; i++) begin
      set_mode(MODES[i], 0);
      op(0, 0, 0, 0, 0, 1, 32'h5000_0000 + 32'(i), 0, 0);
    end
    for (int i = 0; i < 7; i++) begin
      set_mode(MODES[i], 0);
      op(0, 0, 0, 0, 0, 0, 0, 13, 8);
    end

    cur_req = "R6";
    set_mode(5'b10000, 27'h1); set_mode(5'b11111, 27'h2); set_mode(5'b10011, 27'h3);

    cur_req = "R7";
    op(0, 0, 0, 1, {27'h7FF_FFFF, 5'b10011}, 0, 0, 13, 14);
    op(1, 13, 32'h7777_0001, 1, {27'h0, 5'b10011}, 0, 0, 13, 14);

    cur_req = "R8";
    op(1, 13, 32'h8888_0001, 1, {27'h0, 5'b10001}, 1, 32'h8888_5555, 13, 9);
    op(1, 9, 32'h8888_0002, 1, {27'h0, 5'b10000}, 0, 0, 9, 13);
    op(0, 0, 0, 1, {27'h0, 5'b10011}, 0, 0, 13, 9);

    cur_req = "R9";
    op(0, 0, 0, 1, {27'h12, 5'b00000}, 0, 0, 13, 14);
    op(1, 14, 32'h9999_0001, 0, 0, 0, 0, 14, 13);
    op(0, 0, 0, 1, {27'h0, 5'b10100}, 0, 0, 14, 13);
    op(0, 0, 0, 1, {27'h0, 5'b10100}, 1, 32'h9999_5555, 14, 13);
    op(0, 0, 0, 1, {27'h0, 5'b10011}, 0, 0, 14, 13);
    op(0, 0, 0, 1, {27'h0, 5'b10111}, 0, 0, 14, 13);

    cur_req = "R2";
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] m;
      m = ($urandom_range(0, 15) == 0) ? (($urandom_range(0, 1) == 0) ? 5'b00000 : 5'b10100)
                                       : MODES[$urandom_range(0, 6)];
      op($urandom_range(0, 1) == 1, 4'($urandom_range(0, 15)), $urandom,
         $urandom_range(0, 3) == 0, {27'($urandom), m},
         $urandom_range(0, 3) == 0, $urandom,
         4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL %s watchdog: actual running expected finished", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule